// File: doc/BRIEF.md
# Dual-Plane Pixel Color Lookup

This block turns 8-bit indexed pixels into 24-bit RGB colour for a display pipeline. Each pixel carries two overlaid planes. A 5-bit static field selects a background colour. A 3-bit dynamic field selects one of eight foreground colours. Static code zero is transparent: wherever the static field holds zero, the dynamic field picks the colour instead.

All colours come from a 32-entry table of 24-bit words. A processor loads the table through a simple write strobe port. The eight dynamic colours sit in the top eight entries.

The looked-up colour then passes through an output register. That register forces black whenever display enable is low, so the retrace borders stay dark. The same gated colour also feeds three 6-bit outputs for external video DACs. Display enable and both sync signals travel through the same two pipeline stages as the colour, so they stay aligned with it.

Top module: `pixel_clut`

## Requirements
- R1: A synchronous active-high reset clears every table entry to zero and drives every output to zero. Reading any entry after reset, before any write, yields 0x000000.
- R2: The pixel is split as static field = pix_i[7:3] and dynamic field = pix_i[2:0]. When the static field is non-zero, the colour is the table entry whose index equals the static field, whatever the dynamic bits hold.
- R3: When the static field is zero (transparent), the colour is table entry 24 + dynamic field, so the entries used are 24 to 31.
- R4: Colour, de_o, hsync_o and vsync_o all appear exactly two clock edges after the pixel, enable and sync inputs are sampled.
- R5: When the delayed display enable is low, rgb_o is 0x000000 and the DAC outputs are 0, regardless of the pixel value.
- R6: rgb_o is packed as R = [23:16], G = [15:8] and B = [7:0]. Each DAC output equals the upper 6 bits of its gated 8-bit channel.
- R7: A write with wr_en_i high stores wr_data_i at wr_addr_i on the next clock edge. A pixel that reads the same entry in that same cycle gets the old value, and a pixel one cycle later gets the new value.
- R8: With wr_en_i low, wr_addr_i and wr_data_i leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_i | input | 8 | Pixel: static field [7:3], dynamic field [2:0] |
| de_i | input | 1 | Display enable for this pixel |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 5 | Table entry to write |
| wr_data_i | input | 24 | Colour to store, R/G/B packed |
| rgb_o | output | 24 | Gated colour, R [23:16], G [15:8], B [7:0] |
| dac_r_o | output | 6 | Red DAC code |
| dac_g_o | output | 6 | Green DAC code |
| dac_b_o | output | 6 | Blue DAC code |
| de_o | output | 1 | Display enable aligned with colour |
| hsync_o | output | 1 | Horizontal sync aligned with colour |
| vsync_o | output | 1 | Vertical sync aligned with colour |

## Verification
The first pattern sweeps every static code with assorted dynamic bits. This separates static indexing from any leakage of the dynamic field. The second pattern holds static code zero and walks all eight dynamic codes, which exposes an offset or bit-order error in the transparent path. A third pattern writes and reads the same entry in back-to-back cycles, which distinguishes read-old-value from write-through behaviour. A fourth pattern toggles display enable and the syncs against distinct colours, which shows a misaligned delay or missing blanking. The table entries carry different low bits per channel, so a wrong DAC slice or channel swap shows up.

// File: rtl/clut_pkg.sv
package clut_pkg;
  // sideband signals that travel with each pixel
  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } vid_ctl_t;

  localparam int NUM_CH = 3;
endpackage

// File: rtl/clut_index.sv
module clut_index #(
  parameter int DYN_W = 3,
  parameter int STA_W = 5
) (
  input  logic [STA_W+DYN_W-1:0] pix,
  output logic [STA_W-1:0]       idx
);
  localparam int ENTRIES  = 1 << STA_W;
  localparam int DYN_BASE = ENTRIES - (1 << DYN_W);

  logic [STA_W-1:0] sta;
  logic [DYN_W-1:0] dyn;

  assign sta = pix[STA_W+DYN_W-1:DYN_W];
  assign dyn = pix[DYN_W-1:0];

  always_comb begin
    if (sta == '0) idx = STA_W'(DYN_BASE) + STA_W'(dyn);
    else           idx = sta;
  end
endmodule

// File: rtl/clut_table.sv
module clut_table #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // write port; reset returns every entry to black
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // registered read sees the contents before any same-edge write
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/clut_gate.sv
module clut_gate
  import clut_pkg::*;
#(
  parameter int CH_W  = 8,
  parameter int DAC_W = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CH*CH_W-1:0]         color_i,
  input  vid_ctl_t                       ctl_i,
  output logic [NUM_CH*CH_W-1:0]         color_o,
  output logic [NUM_CH-1:0][DAC_W-1:0]   dac_o,
  output vid_ctl_t                       ctl_o
);
  logic [NUM_CH*CH_W-1:0] gated;

  assign gated = ctl_i.de ? color_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      color_o <= '0;
      ctl_o   <= '0;
    end else begin
      color_o <= gated;
      ctl_o   <= ctl_i;
    end
  end

  // channel 0 is blue (lowest byte), channel NUM_CH-1 is red
  for (genvar c = 0; c < NUM_CH; c++) begin : g_dac
    always_ff @(posedge clk) begin
      if (rst) dac_o[c] <= '0;
      else     dac_o[c] <= gated[c*CH_W + CH_W - 1 -: DAC_W];
    end
  end
endmodule

// File: rtl/pixel_clut.sv
module pixel_clut
  import clut_pkg::*;
#(
  parameter int DYN_W = 3,
  parameter int STA_W = 5,
  parameter int CH_W  = 8,
  parameter int DAC_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [STA_W+DYN_W-1:0] pix_i,
  input  logic                   de_i,
  input  logic                   hsync_i,
  input  logic                   vsync_i,
  input  logic                   wr_en_i,
  input  logic [STA_W-1:0]       wr_addr_i,
  input  logic [3*CH_W-1:0]      wr_data_i,
  output logic [3*CH_W-1:0]      rgb_o,
  output logic [DAC_W-1:0]       dac_r_o,
  output logic [DAC_W-1:0]       dac_g_o,
  output logic [DAC_W-1:0]       dac_b_o,
  output logic                   de_o,
  output logic                   hsync_o,
  output logic                   vsync_o
);
  localparam int COL_W = NUM_CH * CH_W;

  logic [STA_W-1:0]             idx;
  logic [COL_W-1:0]             tbl_color;
  vid_ctl_t                     ctl_s1;
  vid_ctl_t                     ctl_s2;
  logic [NUM_CH-1:0][DAC_W-1:0] dac;

  clut_index #(.DYN_W(DYN_W), .STA_W(STA_W)) u_index (
    .pix (pix_i),
    .idx (idx)
  );

  clut_table #(.ADDR_W(STA_W), .DATA_W(COL_W)) u_table (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en_i),
    .waddr (wr_addr_i),
    .wdata (wr_data_i),
    .raddr (idx),
    .rdata (tbl_color)
  );

  // sideband delay matching the table read stage
  always_ff @(posedge clk) begin
    if (rst) ctl_s1 <= '0;
    else     ctl_s1 <= '{de: de_i, hs: hsync_i, vs: vsync_i};
  end

  clut_gate #(.CH_W(CH_W), .DAC_W(DAC_W)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .color_i (tbl_color),
    .ctl_i   (ctl_s1),
    .color_o (rgb_o),
    .dac_o   (dac),
    .ctl_o   (ctl_s2)
  );

  assign dac_r_o = dac[2];
  assign dac_g_o = dac[1];
  assign dac_b_o = dac[0];
  assign de_o    = ctl_s2.de;
  assign hsync_o = ctl_s2.hs;
  assign vsync_o = ctl_s2.vs;
endmodule

// File: rtl/pixel_clut_chk.sv
module pixel_clut_chk #(
  parameter int CH_W  = 8,
  parameter int DAC_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              de_i,
  input logic              hsync_i,
  input logic              vsync_i,
  input logic [3*CH_W-1:0] rgb_o,
  input logic [DAC_W-1:0]  dac_r_o,
  input logic [DAC_W-1:0]  dac_g_o,
  input logic [DAC_W-1:0]  dac_b_o,
  input logic              de_o,
  input logic              hsync_o,
  input logic              vsync_o
);
  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rgb_o == '0 && !de_o && !hsync_o && !vsync_o));

  // R4
  de_align_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (de_o == $past(de_i, 2)));

  // R4
  sync_align_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (hsync_o == $past(hsync_i, 2) && vsync_o == $past(vsync_i, 2)));

  // R5
  blank_black_chk: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (rgb_o == '0 && dac_r_o == '0 && dac_g_o == '0 && dac_b_o == '0));

  // R6
  dac_slice_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_r_o == rgb_o[3*CH_W-1 -: DAC_W] &&
     dac_g_o == rgb_o[2*CH_W-1 -: DAC_W] &&
     dac_b_o == rgb_o[CH_W-1 -: DAC_W]));
endmodule

bind pixel_clut pixel_clut_chk #(.CH_W(CH_W), .DAC_W(DAC_W)) u_chk (.*);

// File: tb/pixel_clut_bench.sv
`timescale 1ns/1ps
module pixel_clut_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pix_i = '0;
  logic        de_i = 1'b0, hsync_i = 1'b0, vsync_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [23:0] wr_data_i = '0;
  logic [23:0] rgb_o;
  logic [5:0]  dac_r_o, dac_g_o, dac_b_o;
  logic        de_o, hsync_o, vsync_o;

  always #2.5 clk = ~clk;

  pixel_clut u_pixel_clut (.*);

  typedef struct {
    logic [23:0] rgb;
    logic        de, hs, vs;
    int          due;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [23:0] mdl [32];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  function automatic logic [23:0] pat(int i);
    return {8'(i*37 + 5), 8'(i*11 + 200), 8'(255 - i*7)};
  endfunction

  function automatic logic [4:0] ref_idx(logic [7:0] p);
    return (p[7:3] == 5'd0) ? 5'(24 + p[2:0]) : p[7:3];
  endfunction

  // driver: compute expectation from model (pre-write), then drive
  task automatic step(input logic [7:0] p, input logic de, input logic hs, input logic vs,
                      input logic we, input logic [4:0] wa, input logic [23:0] wd,
                      input string req);
    exp_t e;
    @(negedge clk);
    e.rgb = de ? mdl[ref_idx(p)] : 24'h0;
    e.de = de; e.hs = hs; e.vs = vs;
    e.due = cyc + 2;
    e.req = req;
    sb.push_back(e);
    if (we) mdl[wa] = wd;
    pix_i = p; de_i = de; hsync_i = hs; vsync_i = vs;
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
  endtask

  task automatic fail_line(string req, string what, logic [23:0] act, logic [23:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  // monitor: pops items as the design produces them
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (rgb_o !== e.rgb) fail_line(e.req, "rgb", rgb_o, e.rgb);
        else if ({dac_r_o, dac_g_o, dac_b_o} !== {e.rgb[23:18], e.rgb[15:10], e.rgb[7:2]})
          fail_line({e.req, "/R6"}, "dac", {6'b0, dac_r_o, dac_g_o, dac_b_o},
                    {6'b0, e.rgb[23:18], e.rgb[15:10], e.rgb[7:2]});
        else if ({de_o, hsync_o, vsync_o} !== {e.de, e.hs, e.vs})
          fail_line({e.req, "/R4"}, "ctl", {21'b0, de_o, hsync_o, vsync_o},
                    {21'b0, e.de, e.hs, e.vs});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 24'h0;
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    n_chk++;
    if ({rgb_o, dac_r_o, dac_g_o, dac_b_o, de_o, hsync_o, vsync_o} !== '0)
      fail_line("R1", "reset outputs", rgb_o, 24'h0);
    @(negedge clk);
    rst = 1'b0;

    // R1: every entry reads black after reset
    for (int i = 0; i < 32; i++) step(8'(i), 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 24'h0, "R1");

    // R7: write each entry while a same-cycle pixel reads it (old), then read (new)
    for (int i = 0; i < 32; i++) begin
      logic [7:0] p;
      p = (i >= 24) ? 8'(i - 24) : {5'(i), 3'(i)};
      if (i == 0) p = 8'h05;
      step(p, 1'b1, 1'b0, 1'b0, 1'b1, 5'(i), pat(i), "R7");
      step(p, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 24'h0, "R7");
    end

    // R2: static codes with varied dynamic bits
    for (int s = 1; s < 32; s++)
      for (int d = 0; d < 8; d += 3)
        step({5'(s), 3'(d)}, 1'b1, 1'(s % 2), 1'b0, 1'b0, 5'd0, 24'h0, "R2");

    // R3: transparent static code selects entries 24..31
    for (int d = 0; d < 8; d++) step({5'd0, 3'(d)}, 1'b1, 1'b0, 1'(d % 2), 1'b0, 5'd0, 24'h0, "R3");

    // R5 and R4: blanking and sync alignment
    for (int k = 0; k < 24; k++)
      step(8'(k * 29 + 3), 1'(k % 3 == 0), 1'(k % 2), 1'(k % 5 == 1), 1'b0, 5'd0, 24'h0,
           (k % 3 == 0) ? "R4" : "R5");

    // R8: strobe low, address and data ignored
    step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 24'hFFFFFF, "R8");
    step(8'h18, 1'b0, 1'b0, 1'b0, 1'b0, 5'd24, 24'hABCDEF, "R8");
    step({5'd5, 3'd2}, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 24'h0, "R8");
    step({5'd0, 3'd0}, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 24'h0, "R8");

    // R6: entries with every low-bit pattern through the DAC slice
    step({5'd0, 3'd0}, 1'b1, 1'b0, 1'b0, 1'b1, 5'd7, 24'hFF_03_80, "R6");
    step({5'd7, 3'd0}, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 24'h0, "R6");
    step({5'd7, 3'd1}, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 24'h0, "R6");

    repeat (6) step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 24'h0, "R5");
    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++;
      fail_line("R4", "undrained items", 24'(sb.size()), 24'h0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule